// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block turns a set of timing fields into the line and frame control signals that a panel needs. Every pixel step, marked by a one-cycle enable on the system clock, advances a horizontal counter. Each line passes through sync, back porch, active and front porch regions, in that order. At the end of each line a vertical counter advances one line, and it passes through the same four regions counted in lines. The outputs are a line sync, a frame sync, a data-enable for the visible window, the pixel coordinates inside that window, a start-of-frame marker and a panel clock.

The horizontal fields are stored one less than the length they describe. The vertical porch fields hold their length directly, so a vertical porch can be zero lines long. Each sync, the data enable and the clock edge have a programmable polarity. The block takes a full copy of the configuration inputs at the first pixel step after reset and again at each frame wrap. Changing the inputs in the middle of a frame therefore never produces a mixed frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted, and after it until the first pixel step, hsync_o, vsync_o, de_o, sof_o and pclk_o are 0 and px_x_o and px_y_o are 0.
- R2: The first pixel step after reset starts a frame at line 0, pixel 0. Each line is, in pixel steps, h_sync_i+1 sync, then h_lead_i+1 back porch, then line_len_i+1 active, then h_tail_i+1 front porch.
- R3: Each frame is, in lines, v_sync_i+1 sync, then v_lead_i back porch, then frame_len_i+1 active, then v_tail_i front porch; a zero porch field removes that porch.
- R4: hsync_o and vsync_o are high while active when the latched polarity bit (hs_pol_i, vs_pol_i) is 1, and low while active when it is 0.
- R5: Data enable is active only when both the horizontal and the vertical counter are in their active regions; de_pol_i set to 1 makes de_o high while active, 0 makes it low.
- R6: While data enable is active, px_x_o counts 0 to line_len_i across the line and px_y_o counts 0 to frame_len_i across the frame; both are 0 at all other times.
- R7: sof_o is 1 exactly while the counters sit at line 0, pixel 0 of a running frame.
- R8: The configuration inputs are latched only at the first pixel step after reset and at the step that wraps the last pixel of the last line; changes at any other time have no effect until then.
- R9: With clk_dbl off, the internal panel clock is 1 for the cycle after each pixel step and 0 otherwise. pclk_o equals it when clk_pol_i is 1 and is its inverse when clk_pol_i is 0.
- R10: With clk_dbl on, the internal panel clock is 1 for the cycle after each pixel step and then toggles every cycle until the next step, so it has two rising edges per step when steps are four cycles apart.
- R11: When pix_en_i is 0 the counters, and so every output except the panel clock, hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | One pixel step per cycle in which it is high |
| line_len_i | input | HW | Active pixels per line minus one |
| h_lead_i | input | HW | Horizontal back porch minus one |
| h_tail_i | input | HW | Horizontal front porch minus one |
| h_sync_i | input | HW | Line sync width minus one |
| frame_len_i | input | VW | Active lines per frame minus one |
| v_lead_i | input | VW | Vertical back porch in lines |
| v_tail_i | input | VW | Vertical front porch in lines |
| v_sync_i | input | VW | Frame sync width minus one, in lines |
| hs_pol_i | input | 1 | Line sync polarity, 1 = active high |
| vs_pol_i | input | 1 | Frame sync polarity, 1 = active high |
| de_pol_i | input | 1 | Data enable polarity, 1 = active high |
| clk_pol_i | input | 1 | 1 = rising panel clock edge at a data change, 0 = falling edge |
| clk_dbl_i | input | 1 | Doubles the panel clock rate |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable for the visible window |
| px_x_o | output | HW | Pixel column in the window |
| px_y_o | output | VW | Line number in the window |
| sof_o | output | 1 | High during the first pixel slot of a frame |
| pclk_o | output | 1 | Panel clock |

## Verification
The assertions assume two things about the inputs. The configuration is a full set of fields sampled only at a frame wrap. pix_en_i is a plain level, with no limit on how often it is high. Under those assumptions they expect the syncs never to overlap data enable, and the start-of-frame marker to fall inside both syncs. The stimulus keeps every field small enough that a frame takes a few hundred cycles. It changes the configuration once mid-frame, in the active region, to show that the change is held off until the frame wraps. It drives pixel steps every cycle, every second cycle and every fourth cycle, so that double-rate clock toggling has room to appear between steps.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

  typedef struct packed {
    logic hs_pol;
    logic vs_pol;
    logic de_pol;
    logic clk_pol;
    logic clk_dbl;
  } tg_mode_t;

  localparam tg_mode_t MODE_RST = '{hs_pol: 1'b1, vs_pol: 1'b1, de_pol: 1'b1,
                                    clk_pol: 1'b1, clk_dbl: 1'b0};

endpackage

// File: rtl/lcd_tg_shadow.sv
module lcd_tg_shadow
  import lcd_tg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [HW-1:0] h_act_i,
  input  logic [HW-1:0] h_lead_i,
  input  logic [HW-1:0] h_tail_i,
  input  logic [HW-1:0] h_sync_i,
  input  logic [VW-1:0] v_act_i,
  input  logic [VW-1:0] v_lead_i,
  input  logic [VW-1:0] v_tail_i,
  input  logic [VW-1:0] v_sync_i,
  input  tg_mode_t      mode_i,
  output logic [HW-1:0] h_act_o,
  output logic [HW-1:0] h_lead_o,
  output logic [HW-1:0] h_tail_o,
  output logic [HW-1:0] h_sync_o,
  output logic [VW-1:0] v_act_o,
  output logic [VW-1:0] v_lead_o,
  output logic [VW-1:0] v_tail_o,
  output logic [VW-1:0] v_sync_o,
  output tg_mode_t      mode_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_act_o  <= '0;
      h_lead_o <= '0;
      h_tail_o <= '0;
      h_sync_o <= '0;
      v_act_o  <= '0;
      v_lead_o <= '0;
      v_tail_o <= '0;
      v_sync_o <= '0;
      mode_o   <= MODE_RST;
    end else if (load_i) begin
      h_act_o  <= h_act_i;
      h_lead_o <= h_lead_i;
      h_tail_o <= h_tail_i;
      h_sync_o <= h_sync_i;
      v_act_o  <= v_act_i;
      v_lead_o <= v_lead_i;
      v_tail_o <= v_tail_i;
      v_sync_o <= v_sync_i;
      mode_o   <= mode_i;
    end
  end

endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int W          = 10,
  parameter bit PORCH_PLUS1 = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] sync_f_i,
  input  logic [W-1:0] lead_f_i,
  input  logic [W-1:0] act_f_i,
  input  logic [W-1:0] tail_f_i,
  output logic [W+2:0] cnt_o,
  output logic         last_o,
  output logic         sync_o,
  output logic         act_o,
  output logic [W-1:0] pos_o
);

  localparam int CW = W + 3;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lead_len, tail_len;
  logic [CW-1:0] sync_end, act_beg, act_end, total;

  // porch fields either store length-1 or the length itself
  generate
    if (PORCH_PLUS1) begin : g_minus_one
      assign lead_len = CW'(lead_f_i) + CW'(1);
      assign tail_len = CW'(tail_f_i) + CW'(1);
    end else begin : g_direct
      assign lead_len = CW'(lead_f_i);
      assign tail_len = CW'(tail_f_i);
    end
  endgenerate

  assign sync_end = CW'(sync_f_i) + CW'(1);
  assign act_beg  = sync_end + lead_len;
  assign act_end  = act_beg + CW'(act_f_i) + CW'(1);
  assign total    = act_end + tail_len;

  assign last_o = (cnt_q == total - CW'(1));
  assign sync_o = (cnt_q < sync_end);
  assign act_o  = (cnt_q >= act_beg) && (cnt_q < act_end);
  assign pos_o  = act_o ? W'(cnt_q - act_beg) : '0;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

endmodule

// File: rtl/lcd_tg_pclk.sv
module lcd_tg_pclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dbl_i,
  input  logic pol_i,
  output logic raw_o,
  output logic pclk_o
);

  logic raw_q, raw_d;

  always_comb begin
    if (step_i)     raw_d = 1'b1;
    else if (dbl_i) raw_d = ~raw_q;
    else            raw_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= raw_d;
  end

  assign raw_o  = raw_q;
  assign pclk_o = pol_i ? raw_q : ~raw_q;

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic [HW-1:0] line_len_i,
  input  logic [HW-1:0] h_lead_i,
  input  logic [HW-1:0] h_tail_i,
  input  logic [HW-1:0] h_sync_i,
  input  logic [VW-1:0] frame_len_i,
  input  logic [VW-1:0] v_lead_i,
  input  logic [VW-1:0] v_tail_i,
  input  logic [VW-1:0] v_sync_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic          de_pol_i,
  input  logic          clk_pol_i,
  input  logic          clk_dbl_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [HW-1:0] px_x_o,
  output logic [VW-1:0] px_y_o,
  output logic          sof_o,
  output logic          pclk_o
);

  localparam int CFG_W = 4 * HW + 4 * VW + $bits(tg_mode_t);

  logic          run_q;
  logic          load, h_step, v_step;
  logic [HW-1:0] sh_h_act, sh_h_lead, sh_h_tail, sh_h_sync;
  logic [VW-1:0] sh_v_act, sh_v_lead, sh_v_tail, sh_v_sync;
  tg_mode_t      mode_in, mode_q;
  logic [HW+2:0] h_cnt;
  logic [VW+2:0] v_cnt;
  logic          h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;
  logic          hs_act, vs_act, de_act, sof_act, pclk_raw;
  logic [CFG_W-1:0] cfg_vec;

  assign mode_in = '{hs_pol: hs_pol_i, vs_pol: vs_pol_i, de_pol: de_pol_i,
                     clk_pol: clk_pol_i, clk_dbl: clk_dbl_i};

  // first step after reset starts the raster without advancing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 1'b0;
    else if (pix_en_i) run_q <= 1'b1;
  end

  assign load   = pix_en_i & (~run_q | (h_last & v_last));
  assign h_step = pix_en_i & run_q;
  assign v_step = h_step & h_last;

  lcd_tg_shadow #(.HW(HW), .VW(VW)) shadow_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .h_act_i (line_len_i),
    .h_lead_i(h_lead_i),
    .h_tail_i(h_tail_i),
    .h_sync_i(h_sync_i),
    .v_act_i (frame_len_i),
    .v_lead_i(v_lead_i),
    .v_tail_i(v_tail_i),
    .v_sync_i(v_sync_i),
    .mode_i  (mode_in),
    .h_act_o (sh_h_act),
    .h_lead_o(sh_h_lead),
    .h_tail_o(sh_h_tail),
    .h_sync_o(sh_h_sync),
    .v_act_o (sh_v_act),
    .v_lead_o(sh_v_lead),
    .v_tail_o(sh_v_tail),
    .v_sync_o(sh_v_sync),
    .mode_o  (mode_q)
  );

  lcd_tg_axis #(.W(HW), .PORCH_PLUS1(1'b1)) h_axis_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (h_step),
    .sync_f_i(sh_h_sync),
    .lead_f_i(sh_h_lead),
    .act_f_i (sh_h_act),
    .tail_f_i(sh_h_tail),
    .cnt_o   (h_cnt),
    .last_o  (h_last),
    .sync_o  (h_sync),
    .act_o   (h_act),
    .pos_o   (h_pos)
  );

  lcd_tg_axis #(.W(VW), .PORCH_PLUS1(1'b0)) v_axis_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (v_step),
    .sync_f_i(sh_v_sync),
    .lead_f_i(sh_v_lead),
    .act_f_i (sh_v_act),
    .tail_f_i(sh_v_tail),
    .cnt_o   (v_cnt),
    .last_o  (v_last),
    .sync_o  (v_sync),
    .act_o   (v_act),
    .pos_o   (v_pos)
  );

  lcd_tg_pclk pclk_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(pix_en_i),
    .dbl_i (mode_q.clk_dbl & run_q),
    .pol_i (mode_q.clk_pol),
    .raw_o (pclk_raw),
    .pclk_o(pclk_o)
  );

  assign hs_act  = run_q & h_sync;
  assign vs_act  = run_q & v_sync;
  assign de_act  = run_q & h_act & v_act;
  assign sof_act = run_q & (h_cnt == '0) & (v_cnt == '0);

  assign hsync_o = mode_q.hs_pol ? hs_act : ~hs_act;
  assign vsync_o = mode_q.vs_pol ? vs_act : ~vs_act;
  assign de_o    = mode_q.de_pol ? de_act : ~de_act;
  assign sof_o   = sof_act;
  assign px_x_o  = de_act ? h_pos : '0;
  assign px_y_o  = de_act ? v_pos : '0;

  assign cfg_vec = {sh_h_act, sh_h_lead, sh_h_tail, sh_h_sync,
                    sh_v_act, sh_v_lead, sh_v_tail, sh_v_sync, mode_q};

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int HW    = 10,
  parameter int VW    = 10,
  parameter int CFG_W = 4 * HW + 4 * VW + 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_en_i,
  input logic             hs_act,
  input logic             vs_act,
  input logic             de_act,
  input logic             sof_act,
  input logic             load,
  input logic             pclk_raw,
  input logic [HW+2:0]    h_cnt,
  input logic [VW+2:0]    v_cnt,
  input logic [HW-1:0]    px_x_o,
  input logic [VW-1:0]    px_y_o,
  input logic [CFG_W-1:0] cfg_vec
);

  // R5: data window never overlaps either sync
  a_r5_de_outside_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_act |-> (!hs_act && !vs_act));

  // R6: coordinates idle outside the window
  a_r6_idle_coords: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_act |-> (px_x_o == '0 && px_y_o == '0));

  // R6: column advances by one between consecutive window steps
  a_r6_x_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(de_act && pix_en_i) && de_act) |-> (px_x_o == $past(px_x_o) + 1'b1));

  // R11: no step, no movement
  a_r11_hold_without_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(h_cnt) && $stable(v_cnt)));

  // R8: latched configuration frozen between frame boundaries
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(cfg_vec));

  // R7: frame start lies inside both syncs
  a_r7_sof_in_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_act |-> (hs_act && vs_act));

  // R9: panel clock high right after every step
  a_r9_pclk_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> pclk_raw);

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.HW(HW), .VW(VW), .CFG_W(CFG_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pix_en_i(pix_en_i),
  .hs_act  (hs_act),
  .vs_act  (vs_act),
  .de_act  (de_act),
  .sof_act (sof_act),
  .load    (load),
  .pclk_raw(pclk_raw),
  .h_cnt   (h_cnt),
  .v_cnt   (v_cnt),
  .px_x_o  (px_x_o),
  .px_y_o  (px_y_o),
  .cfg_vec (cfg_vec)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;

  localparam int HW = 10;
  localparam int VW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          pix_en = 1'b0;
  logic [HW-1:0] line_len = '0, h_lead = '0, h_tail = '0, h_sync = '0;
  logic [VW-1:0] frame_len = '0, v_lead = '0, v_tail = '0, v_sync = '0;
  logic          hs_pol = 1'b1, vs_pol = 1'b1, de_pol = 1'b1, clk_pol = 1'b1, clk_dbl = 1'b0;

  logic          hsync, vsync, de, sof, pclk;
  logic [HW-1:0] px_x;
  logic [VW-1:0] px_y;

  lcd_timing_gen #(.HW(HW), .VW(VW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en),
    .line_len_i(line_len), .h_lead_i(h_lead), .h_tail_i(h_tail), .h_sync_i(h_sync),
    .frame_len_i(frame_len), .v_lead_i(v_lead), .v_tail_i(v_tail), .v_sync_i(v_sync),
    .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .de_pol_i(de_pol),
    .clk_pol_i(clk_pol), .clk_dbl_i(clk_dbl),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .px_x_o(px_x), .px_y_o(px_y),
    .sof_o(sof), .pclk_o(pclk)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int m_run, m_h, m_v, m_raw;
  int s_ppl, s_blw, s_elw, s_hsw, s_lpp, s_bfw, s_efw, s_vsw;
  int s_hp, s_vp, s_dp, s_cp, s_dbl;

  function automatic void take_cfg();
    s_ppl = line_len; s_blw = h_lead; s_elw = h_tail; s_hsw = h_sync;
    s_lpp = frame_len; s_bfw = v_lead; s_efw = v_tail; s_vsw = v_sync;
    s_hp = hs_pol; s_vp = vs_pol; s_dp = de_pol; s_cp = clk_pol; s_dbl = clk_dbl;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0; m_raw = 0;
      s_ppl = 0; s_blw = 0; s_elw = 0; s_hsw = 0;
      s_lpp = 0; s_bfw = 0; s_efw = 0; s_vsw = 0;
      s_hp = 1; s_vp = 1; s_dp = 1; s_cp = 1; s_dbl = 0;
    end else begin
      int ht, vt;
      if (pix_en) m_raw = 1;
      else if (s_dbl != 0 && m_run != 0) m_raw = 1 - m_raw;
      else m_raw = 0;
      ht = (s_hsw + 1) + (s_blw + 1) + (s_ppl + 1) + (s_elw + 1);
      vt = (s_vsw + 1) + s_bfw + (s_lpp + 1) + s_efw;
      if (pix_en) begin
        if (m_run == 0) begin
          take_cfg();
          m_run = 1;
        end else if (m_h == ht - 1) begin
          m_h = 0;
          if (m_v == vt - 1) begin
            m_v = 0;
            take_cfg();
          end else m_v++;
        end else m_h++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    begin
      int hs, vs, ha, va, dact, hb, vb, ex, ey;
      hb = s_hsw + 1 + s_blw + 1;
      vb = s_vsw + 1 + s_bfw;
      hs = (m_run != 0 && m_h < s_hsw + 1) ? 1 : 0;
      vs = (m_run != 0 && m_v < s_vsw + 1) ? 1 : 0;
      ha = (m_h >= hb && m_h < hb + s_ppl + 1) ? 1 : 0;
      va = (m_v >= vb && m_v < vb + s_lpp + 1) ? 1 : 0;
      dact = (m_run != 0 && ha != 0 && va != 0) ? 1 : 0;
      ex = dact ? m_h - hb : 0;
      ey = dact ? m_v - vb : 0;
      chk("R2/R4 hsync", hsync, s_hp ? hs : 1 - hs);
      chk("R3/R4 vsync", vsync, s_vp ? vs : 1 - vs);
      chk("R5/R8 de", de, s_dp ? dact : 1 - dact);
      chk("R6/R11 px_x", px_x, ex);
      chk("R6/R11 px_y", px_y, ey);
      chk("R7 sof", sof, (m_run != 0 && m_h == 0 && m_v == 0) ? 1 : 0);
      chk("R9/R10 pclk", pclk, s_cp ? m_raw : 1 - m_raw);
    end
  end

  int div = 1;
  int phase = 0;

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_en = ((phase % div) == 0);
      phase++;
    end
  endtask

  task automatic check_idle(string tag);
    chk(tag, {hsync, vsync, de, sof, pclk}, 0);
    chk(tag, px_x, 0);
    chk(tag, px_y, 0);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // config A: 13-step lines, 8-line frames
    line_len = 7; h_lead = 1; h_tail = 0; h_sync = 1;
    frame_len = 3; v_lead = 1; v_tail = 2; v_sync = 0;
    hs_pol = 1; vs_pol = 1; de_pol = 1; clk_pol = 1; clk_dbl = 0;

    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 before first step");

    div = 1; phase = 0;
    run_cycles(250);

    // one full frame window after a start-of-frame sample
    do begin @(posedge clk); #1; end while (!sof);
    begin
      int n_de, n_hs, n_vs;
      n_de = 0; n_hs = 0; n_vs = 0;
      for (int i = 0; i < 104; i++) begin
        @(posedge clk); #1;
        n_de += de; n_hs += hsync; n_vs += vsync;
      end
      chk("R5 window pixels per frame", n_de, 32);
      chk("R2 sync steps per frame", n_hs, 16);
      chk("R3 sync steps per frame", n_vs, 13);
    end

    // mid-frame change: must not touch the running frame
    do begin @(posedge clk); #1; end while (!(de && px_x == 0));
    @(negedge clk);
    line_len = 3; h_lead = 0; h_tail = 1; h_sync = 0;
    frame_len = 1; v_lead = 0; v_tail = 0; v_sync = 1;
    hs_pol = 0; vs_pol = 0; de_pol = 0; clk_pol = 0; clk_dbl = 1;
    pix_en = 1;
    @(posedge clk); #1;
    chk("R8 old polarity kept", de, 1);
    chk("R8 old line kept", px_x, 1);

    div = 4; phase = 1;
    run_cycles(600);

    // double-rate clock pattern after a step, clk_pol 0
    @(negedge clk); pix_en = 1;
    @(posedge clk); #1; chk("R10 step phase", pclk, 0);
    @(negedge clk); pix_en = 0;
    @(posedge clk); #1; chk("R10 toggle 1", pclk, 1);
    @(negedge clk); pix_en = 0;
    @(posedge clk); #1; chk("R10 toggle 2", pclk, 0);

    // config C: both zero-length vertical front porch and normal clock
    line_len = 15; h_lead = 2; h_tail = 3; h_sync = 0;
    frame_len = 5; v_lead = 2; v_tail = 0; v_sync = 2;
    hs_pol = 1; vs_pol = 0; de_pol = 0; clk_pol = 1; clk_dbl = 0;
    div = 2; phase = 0;
    run_cycles(1300);

    // hold without steps
    begin
      int hx, hy, hh;
      @(negedge clk); pix_en = 0;
      @(posedge clk); #1;
      hx = px_x; hy = px_y; hh = hsync;
      for (int i = 0; i < 5; i++) begin
        @(posedge clk); #1;
        chk("R11 x held", px_x, hx);
        chk("R11 y held", px_y, hy);
        chk("R11 hsync held", hsync, hh);
      end
    end
    run_cycles(200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule